// File: doc/BRIEF.md
# Prime-Bank Interleaved Address Generator

This block turns a vector access, given as a start linear address and an element count, into per-element bank selects and in-bank row addresses for a memory of seventeen banks. Each row of that memory holds sixteen elements. The bank of an element is its linear address modulo seventeen, and its row is the linear address divided by sixteen, so one bank per row is left unused. Because seventeen is prime, strided accesses seldom collide on a bank. A fetch or store stage consumes the output. That stage receives one group of up to sixteen consecutive element addresses per accepted cycle, together with a per-lane valid mask.

No divider is used to find the bank. A short shift-and-subtract loop reduces the start address modulo seventeen once, when the job starts. After that, the banks follow a counter recurrence. Inside a group, each lane is one bank above its neighbour, wrapping from 16 to 0. From one group to the next, the base bank steps down by one, because adding sixteen is the same as subtracting one modulo seventeen.

The caller must keep the start address plus the element count at or below 2^AW.

Top module: `pbank_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no job started, out_valid_o and busy_o are 0.
- R2: A job starts when start_i is 1, busy_o is 0 and elem_count_i is nonzero. busy_o is then 1 on the following cycle. A start_i while busy_o is 1 has no effect. A start_i with elem_count_i of 0 has no effect, and busy_o stays 0.
- R3: A job of N elements yields ceil(N/16) groups. In group g, lane j carries element 16g+j, which has address start+16g+j. out_lane_valid_o bit j is 1 exactly when 16g+j < N, so the set lanes are contiguous from lane 0.
- R4: The row field of each valid lane equals its linear address divided by 16. Lane j's row occupies out_row_o bits [j*12 +: 12].
- R5: The bank field of each valid lane equals its linear address modulo 17. Lane j's bank occupies out_bank_o bits [j*5 +: 5].
- R6: Within one group, the valid lanes carry pairwise distinct banks, and each lane's bank is one above the previous lane's bank, wrapping from 16 to 0.
- R7: While out_valid_o is 1 and out_ready_i is 0, the group and its mask are held unchanged. A group advances only on a cycle with both out_valid_o and out_ready_i at 1.
- R8: On the cycle after the last group is accepted, out_valid_o and busy_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request for a new job |
| start_addr_i | input | 16 | Linear address of the first element |
| elem_count_i | input | 12 | Number of elements in the job |
| busy_o | output | 1 | A job is being seeded or emitted |
| out_valid_o | output | 1 | A group is presented |
| out_ready_i | input | 1 | The consumer accepts the presented group |
| out_lane_valid_o | output | 16 | Per-lane valid mask |
| out_bank_o | output | 80 | Bank number per lane, 5 bits each |
| out_row_o | output | 192 | Row address per lane, 12 bits each |

## Verification
Start addresses aligned to sixteen check that the row and the bank offset advance together. Unaligned start addresses place the row carry in the middle of a group, which separates the row carry from the bank wrap. Counts of 1, 16, 17 and non-multiples of sixteen exercise full and partial last groups. Random back-pressure distinguishes correct holding from premature advance. A job that ends at the top of the address space and a long job of 4095 elements exercise the seed reduction at its largest inputs and the group-to-group recurrence across many wraps. Each result is compared with banks computed by a true modulo and rows computed by a true division.

// File: rtl/pbank_pkg.sv
package pbank_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_EMIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/pbank_bank_seed.sv
// Reduces a start address modulo NBANKS with one conditional subtract of
// NBANKS<<k per cycle, k running from KMAX down to 0.
module pbank_bank_seed #(
  parameter int AW        = 16,
  parameter int LANE_BITS = 4,
  parameter int NBANKS    = (1 << LANE_BITS) + 1,
  parameter int BW        = $clog2(NBANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  output logic          done_o,
  output logic [BW-1:0] bank_o
);

  localparam int RMW  = AW + 1;
  localparam int KMAX = AW - LANE_BITS;
  localparam int KW   = $clog2(KMAX + 1);

  logic [RMW-1:0] rem_q, rem_d, rem_step, sub_val;
  logic [KW-1:0]  k_q, k_d;
  logic           act_q, act_d;
  logic           ge;

  // Datapath of one reduction step.
  always_comb begin
    sub_val  = RMW'(NBANKS) << k_q;
    ge       = (rem_q >= sub_val);
    rem_step = ge ? (rem_q - sub_val) : rem_q;
  end

  // Next-state logic.
  always_comb begin
    rem_d = rem_q;
    k_d   = k_q;
    act_d = act_q;
    if (load_i) begin
      rem_d = {1'b0, addr_i};
      k_d   = KW'(KMAX);
      act_d = 1'b1;
    end else if (act_q) begin
      rem_d = rem_step;
      if (k_q == '0) begin
        act_d = 1'b0;
      end else begin
        k_d = k_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      k_q   <= '0;
      act_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      k_q   <= k_d;
      act_q <= act_d;
    end
  end

  assign done_o = act_q && (k_q == '0);
  assign bank_o = rem_step[BW-1:0];

  AST_SEED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rem_step < RMW'(NBANKS))); // R5

endmodule

// File: rtl/pbank_lane_map.sv
// Expands a group base (address, bank, remaining count) into per-lane fields.
module pbank_lane_map #(
  parameter int AW        = 16,
  parameter int LANE_BITS = 4,
  parameter int CW        = 12,
  parameter int NBANKS    = (1 << LANE_BITS) + 1,
  parameter int BW        = $clog2(NBANKS),
  parameter int LANES     = 1 << LANE_BITS,
  parameter int RW        = AW - LANE_BITS
) (
  input  logic [AW-1:0]       base_addr_i,
  input  logic [BW-1:0]       base_bank_i,
  input  logic [CW-1:0]       remaining_i,
  output logic [LANES-1:0]    lane_valid_o,
  output logic [LANES*BW-1:0] bank_o,
  output logic [LANES*RW-1:0] row_o
);

  logic [RW-1:0]        base_row;
  logic [LANE_BITS-1:0] base_lo;

  assign base_row = base_addr_i[AW-1:LANE_BITS];
  assign base_lo  = base_addr_i[LANE_BITS-1:0];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [BW:0]        bsum;
    logic [LANE_BITS:0] lo_sum;
    logic               row_carry;

    // Bank: base plus lane index, wrapped once at NBANKS.
    assign bsum = {1'b0, base_bank_i} + (BW+1)'(j);
    assign bank_o[j*BW +: BW] = (bsum >= (BW+1)'(NBANKS))
                                ? BW'(bsum - (BW+1)'(NBANKS))
                                : bsum[BW-1:0];

    // Row: bumps when the low address bits wrap within the group.
    assign lo_sum    = {1'b0, base_lo} + (LANE_BITS+1)'(j);
    assign row_carry = (lo_sum >= (LANE_BITS+1)'(LANES));
    assign row_o[j*RW +: RW] = base_row + RW'(row_carry);

    assign lane_valid_o[j] = (remaining_i > CW'(j));
  end

endmodule

// File: rtl/pbank_addr_gen.sv
module pbank_addr_gen
  import pbank_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LANE_BITS = 4,
  parameter int CW        = 12,
  parameter int NBANKS    = (1 << LANE_BITS) + 1,
  parameter int BW        = $clog2(NBANKS),
  parameter int LANES     = 1 << LANE_BITS,
  parameter int RW        = AW - LANE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [AW-1:0]       start_addr_i,
  input  logic [CW-1:0]       elem_count_i,
  output logic                busy_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [LANES-1:0]    out_lane_valid_o,
  output logic [LANES*BW-1:0] out_bank_o,
  output logic [LANES*RW-1:0] out_row_o
);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [BW-1:0] bank_q, bank_d;
  logic          accept, last_grp, seed_done;
  logic [BW-1:0] seed_bank;
  logic          state_en;

  assign accept   = start_i && (state_q == ST_IDLE) && (elem_count_i != '0);
  assign last_grp = (rem_q <= CW'(LANES));

  pbank_bank_seed #(
    .AW(AW), .LANE_BITS(LANE_BITS), .NBANKS(NBANKS), .BW(BW)
  ) u_seed (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .addr_i (start_addr_i),
    .done_o (seed_done),
    .bank_o (seed_bank)
  );

  // Next-state logic of the sequencer.
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    bank_d  = bank_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SEED;
          addr_d  = start_addr_i;
          rem_d   = elem_count_i;
        end
      end
      ST_SEED: begin
        if (seed_done) begin
          state_d = ST_EMIT;
          bank_d  = seed_bank;
        end
      end
      ST_EMIT: begin
        if (out_ready_i) begin
          addr_d = addr_q + AW'(LANES);
          // Adding LANES equals subtracting one modulo NBANKS.
          bank_d = (bank_q == '0) ? BW'(NBANKS - 1) : (bank_q - 1'b1);
          if (last_grp) begin
            state_d = ST_IDLE;
            rem_d   = '0;
          end else begin
            rem_d = rem_q - CW'(LANES);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q) || (state_q == ST_EMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      bank_q  <= '0;
    end else if (state_en) begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      bank_q  <= bank_d;
    end
  end

  pbank_lane_map #(
    .AW(AW), .LANE_BITS(LANE_BITS), .CW(CW), .NBANKS(NBANKS),
    .BW(BW), .LANES(LANES), .RW(RW)
  ) u_map (
    .base_addr_i  (addr_q),
    .base_bank_i  (bank_q),
    .remaining_i  (rem_q),
    .lane_valid_o (out_lane_valid_o),
    .bank_o       (out_bank_o),
    .row_o        (out_row_o)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign out_valid_o = (state_q == ST_EMIT);

  // Assertions
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_bank_o)
      && $stable(out_row_o) && $stable(out_lane_valid_o))); // R7

  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && last_grp) |=> (!out_valid_o && !busy_o)); // R8

  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((out_lane_valid_o != '0)
      && ((out_lane_valid_o & (out_lane_valid_o + 1'b1)) == '0))); // R3

  AST_BASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (bank_q < BW'(NBANKS))); // R5

  AST_GROUP_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !last_grp) |=>
      (out_bank_o[BW-1:0] ==
        (($past(out_bank_o[(LANES-1)*BW +: BW]) == BW'(NBANKS - 1)) ? BW'(0)
          : BW'($past(out_bank_o[(LANES-1)*BW +: BW]) + 1'b1)))); // R5

  AST_IDLE_NO_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && (elem_count_i == '0)) |=> !busy_o); // R2

  for (genvar j = 1; j < LANES; j++) begin : g_chk
    AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_lane_valid_o[j]) |->
        (out_bank_o[j*BW +: BW] ==
          ((out_bank_o[(j-1)*BW +: BW] == BW'(NBANKS - 1)) ? BW'(0)
            : BW'(out_bank_o[(j-1)*BW +: BW] + 1'b1)))); // R6
  end

endmodule

// File: tb/pbank_addr_gen_tb_top.sv
module pbank_addr_gen_tb_top;

  localparam int AW = 16;
  localparam int CW = 12;
  localparam int LN = 16;
  localparam int BW = 5;
  localparam int RW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] elem_count = '0;
  logic out_ready = 1'b0;
  logic busy, out_valid;
  logic [LN-1:0] lane_valid;
  logic [LN*BW-1:0] bank;
  logic [LN*RW-1:0] row;

  int checks = 0;
  int failures = 0;
  int cyc_total = 0;

  logic [LN-1:0]    prev_mask;
  logic [LN*BW-1:0] prev_bank;
  logic [LN*RW-1:0] prev_row;

  always #2 clk = ~clk;

  pbank_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
    .elem_count_i(elem_count), .busy_o(busy), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_lane_valid_o(lane_valid),
    .out_bank_o(bank), .out_row_o(row)
  );

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total == 150000) begin
      failures++;
      $display("FAIL R7 watchdog expired actual=%0d expected<%0d", cyc_total, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int exp_bank(int a);
    return a % 17;
  endfunction

  function automatic int exp_row(int a);
    return a / 16;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_group(int a, int n, int g, bit after_stall);
    logic [LN-1:0] em;
    int bad_b, bad_r, dup, fb_a, fb_e, fr_a, fr_e;
    bit seen[17];
    bad_b = 0; bad_r = 0; dup = 0; fb_a = 0; fb_e = 0; fr_a = 0; fr_e = 0;
    for (int k = 0; k < 17; k++) seen[k] = 1'b0;
    for (int j = 0; j < LN; j++) em[j] = ((16*g + j) < n);
    chk(lane_valid === em, "R3 lane mask", int'(lane_valid), int'(em));
    for (int j = 0; j < LN; j++) begin
      if (em[j]) begin
        int ad, bv, rv;
        ad = a + 16*g + j;
        bv = int'(bank[j*BW +: BW]);
        rv = int'(row[j*RW +: RW]);
        if (bv != exp_bank(ad)) begin
          if (bad_b == 0) begin fb_a = bv; fb_e = exp_bank(ad); end
          bad_b++;
        end
        if (rv != exp_row(ad)) begin
          if (bad_r == 0) begin fr_a = rv; fr_e = exp_row(ad); end
          bad_r++;
        end
        if (bv < 17) begin
          if (seen[bv]) dup++;
          seen[bv] = 1'b1;
        end
      end
    end
    chk(bad_b == 0, "R5 bank modulo 17", fb_a, fb_e);
    chk(bad_r == 0, "R4 row divide 16", fr_a, fr_e);
    chk(dup == 0, "R6 distinct banks (duplicates)", dup, 0);
    if (after_stall) begin
      chk((bank === prev_bank) && (row === prev_row) && (lane_valid === prev_mask),
          "R7 hold under stall", int'(lane_valid), int'(prev_mask));
    end
    prev_bank = bank;
    prev_row  = row;
    prev_mask = lane_valid;
  endtask

  task automatic run_job(int a, int n, bit poke);
    int ngroups, g, cyc;
    bit stalled, poked;
    @(negedge clk);
    start = 1'b1;
    start_addr = AW'(a);
    elem_count = CW'(n);
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(!busy && !out_valid, "R2 zero count ignored", int'(busy), 0);
      return;
    end
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    ngroups = (n + 15) / 16;
    g = 0; cyc = 0; stalled = 1'b0; poked = 1'b0;
    while (g < ngroups && cyc < 5000) begin
      if (poke && !poked) begin
        start = 1'b1;
        start_addr = AW'($urandom % 1000);
        elem_count = CW'(5);
        poked = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (out_valid) begin
        check_group(a, n, g, stalled);
        if (($urandom % 4) != 0) begin
          out_ready = 1'b1;
          stalled = 1'b0;
          g++;
        end else begin
          out_ready = 1'b0;
          stalled = 1'b1;
        end
      end else begin
        out_ready = 1'($urandom % 2);
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    out_ready = 1'b0;
    chk(g == ngroups, "R3 group count", g, ngroups);
    chk(!out_valid && !busy, "R8 idle after last group", int'(out_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy, "R1 idle after reset", int'(out_valid), 0);

    run_job(0, 16, 1'b0);
    run_job(5, 1, 1'b0);
    run_job(0, 0, 1'b0);
    run_job(13, 40, 1'b1);
    run_job(51, 33, 1'b0);
    run_job(65520, 16, 1'b0);
    run_job(65000, 536, 1'b0);
    run_job(7, 4095, 1'b0);
    for (int t = 0; t < 25; t++) begin
      int n, a;
      n = int'($urandom % 300);
      a = int'($urandom % (65537 - n));
      run_job(a, n, (t % 5) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule